// File: doc/BRIEF.md
# Chainable Eight-Input Serializer

This block models one industrial digital-input serializer. Eight field inputs pass through a per-input debounce filter. On the falling edge of an active-low select, the filtered byte is loaded into a shift register, together with an optional status byte. The status byte carries a 5-bit check code over the data byte and three alarm flags. The master then clocks the word out MSB first on a serial clock.

A serial input is shifted into the bottom of the chip's own word. After the chip's own bits have gone out, the bits of a downstream chip follow on its output. Any number of chips can therefore be chained, and the master receives the word of the nearest chip first.

The link signals, the debounce selection and the alarm inputs are all sampled on the block clock. A mode pin, latched at the same select edge, sets the word to 8 or 16 bits. A registered fault output reports a live alarm.

Top module: `din_serializer`

## Requirements
- R1: While reset is held and after its release, `sdo` and `fault` are 0.
- R2: In the clock after `cs_n` is first seen low, the shift register loads. `sdo` then shows data bit 7, and each `sck` rising edge seen while selected moves the next bit out, MSB first. With `word8_sel`=1 at the load, the word is the 8-bit data byte only.
- R3: With `word8_sel`=0 at the load, the word is 16 bits: the data byte first, then the status byte.
- R4: Status bits [7:3] hold a 5-bit CRC of the data byte, computed MSB first from a zero start with generator x^5+x^4+x^2+1.
- R5: Status bit 2 is the inverse of `uv_alarm`, bit 1 equals `over_temp`, and bit 0 is the inverse of `uv_warn`, all sampled at the load.
- R6: Once the chip's own word is shifted out (8 or 16 bits), the bits taken from `sdi` appear on `sdo` in arrival order. In a chain, the nearest chip's word comes first.
- R7: Changes to the field inputs or the alarm inputs after the load do not alter the word being shifted out.
- R8: `fault` is the OR of `over_temp` and `uv_alarm`, one clock after they are sampled.
- R9: `db_sel` selects the filter, encoded as 00 = none, 01 = short (4 clocks), 10 = medium (16 clocks), 11 = long (64 clocks). With 00, an input change is taken on the next clock. Otherwise an input must differ from the filtered value for that many consecutive clocks before it is taken, and shorter pulses are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_raw | input | 8 | Field inputs before filtering |
| db_sel | input | 2 | Debounce setting |
| word8_sel | input | 1 | 1 = data byte only, 0 = data plus status |
| uv_alarm | input | 1 | Undervoltage alarm condition, active high |
| uv_warn | input | 1 | Undervoltage warning condition, active high |
| over_temp | input | 1 | Overtemperature condition, active high |
| cs_n | input | 1 | Active-low select; its falling edge loads the word |
| sck | input | 1 | Serial clock; a rising edge shifts one bit |
| sdi | input | 1 | Serial input from the downstream chip |
| sdo | output | 1 | Serial output, MSB first |
| fault | output | 1 | Registered alarm summary |

## Verification
The load takes effect one block clock after `cs_n` is seen low. Each new output bit appears one clock after a seen `sck` rise. `fault` follows its inputs by one clock. A filtered input is taken one clock after a change with no filter, or after 4, 16 or 64 steady clocks otherwise. The bench drives every input on the falling clock edge and samples on the next falling edge, after the register concerned has updated. Before each load it leaves at least two clocks, or more than the filter length, so captured values are settled. It reads two chained instances in one frame, so pass-through order is compared bit for bit against words computed in the bench.

// File: rtl/dinser_pkg.sv
package dinser_pkg;
  localparam int unsigned DATA_W = 8;
  localparam int unsigned CRC_W  = 5;
  localparam logic [CRC_W-1:0] CRC_GEN = 5'b10101;

  typedef enum logic [1:0] {
    DB_NONE   = 2'b00,
    DB_SHORT  = 2'b01,
    DB_MEDIUM = 2'b10,
    DB_LONG   = 2'b11
  } db_sel_e;

  function automatic logic [CRC_W-1:0] crc5_of(input logic [DATA_W-1:0] d);
    logic [CRC_W-1:0] r;
    logic             fb;
    r = '0;
    for (int i = DATA_W - 1; i >= 0; i--) begin
      fb = r[CRC_W-1] ^ d[i];
      r  = {r[CRC_W-2:0], 1'b0};
      if (fb) r = r ^ CRC_GEN;
    end
    return r;
  endfunction
endpackage

// File: rtl/dinser_debounce.sv
module dinser_debounce
  import dinser_pkg::*;
#(
  parameter int unsigned SHORT_CYC = 4,
  parameter int unsigned MED_CYC   = 16,
  parameter int unsigned LONG_CYC  = 64
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] sel,
  input  logic       raw,
  output logic       filt
);
  localparam int unsigned CNT_W = $clog2(LONG_CYC + 1);

  logic [CNT_W-1:0] cnt_q, cnt_d, lim_m1;
  logic             filt_q, filt_d;

  always_comb begin
    case (sel)
      DB_SHORT:  lim_m1 = CNT_W'(SHORT_CYC - 1);
      DB_MEDIUM: lim_m1 = CNT_W'(MED_CYC - 1);
      default:   lim_m1 = CNT_W'(LONG_CYC - 1);
    endcase
  end

  always_comb begin
    filt_d = filt_q;
    cnt_d  = '0;
    if (sel == DB_NONE) begin
      filt_d = raw;
    end else if (raw != filt_q) begin
      if (cnt_q >= lim_m1) filt_d = raw;
      else                 cnt_d  = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      filt_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      filt_q <= filt_d;
      cnt_q  <= cnt_d;
    end
  end

  assign filt = filt_q;

  assert_cnt_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(LONG_CYC - 1));
  assert_take_raw_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(filt_q) |-> filt_q == $past(raw));
endmodule

// File: rtl/dinser_shift.sv
module dinser_shift #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              sck,
  input  logic              sdi,
  input  logic              word8,
  input  logic [DATA_W-1:0] data,
  input  logic [DATA_W-1:0] status,
  output logic              sdo
);
  localparam int unsigned SR_W = 2 * DATA_W;

  logic            cs_q, sck_q, mode8_q, mode8_d;
  logic [SR_W-1:0] sr_q, sr_d;
  logic            load, shift_en;

  assign load     = cs_q & ~cs_n;
  assign shift_en = ~cs_n & ~cs_q & sck & ~sck_q;

  always_comb begin
    sr_d    = sr_q;
    mode8_d = mode8_q;
    if (load) begin
      mode8_d = word8;
      sr_d    = word8 ? {data, {DATA_W{1'b0}}} : {data, status};
    end else if (shift_en) begin
      if (mode8_q) sr_d = {sr_q[SR_W-2:DATA_W], sdi, {DATA_W{1'b0}}};
      else         sr_d = {sr_q[SR_W-2:0], sdi};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_q    <= 1'b1;
      sck_q   <= 1'b0;
      sr_q    <= '0;
      mode8_q <= 1'b0;
    end else begin
      cs_q    <= cs_n;
      sck_q   <= sck;
      sr_q    <= sr_d;
      mode8_q <= mode8_d;
    end
  end

  assign sdo = sr_q[SR_W-1];

  assert_idle_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_q && cs_n) |=> $stable(sr_q));
  assert_load_msb_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_q && !cs_n) |=> sdo == $past(data[DATA_W-1]));
  assert_pass_in8_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_en && mode8_q) |=> sr_q[DATA_W] == $past(sdi));
  assert_pass_in16_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_en && !mode8_q) |=> sr_q[0] == $past(sdi));
endmodule

// File: rtl/din_serializer.sv
module din_serializer
  import dinser_pkg::*;
#(
  parameter int unsigned DB_SHORT_CYC = 4,
  parameter int unsigned DB_MED_CYC   = 16,
  parameter int unsigned DB_LONG_CYC  = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] in_raw,
  input  logic [1:0]        db_sel,
  input  logic              word8_sel,
  input  logic              uv_alarm,
  input  logic              uv_warn,
  input  logic              over_temp,
  input  logic              cs_n,
  input  logic              sck,
  input  logic              sdi,
  output logic              sdo,
  output logic              fault
);
  logic [DATA_W-1:0] filt;
  logic [DATA_W-1:0] status;
  logic              fault_q, fault_d;

  for (genvar g = 0; g < DATA_W; g++) begin : g_db
    dinser_debounce #(
      .SHORT_CYC(DB_SHORT_CYC),
      .MED_CYC  (DB_MED_CYC),
      .LONG_CYC (DB_LONG_CYC)
    ) u_db (
      .clk  (clk),
      .rst_n(rst_n),
      .sel  (db_sel),
      .raw  (in_raw[g]),
      .filt (filt[g])
    );
  end

  assign status = {crc5_of(filt), ~uv_alarm, over_temp, ~uv_warn};

  dinser_shift #(.DATA_W(DATA_W)) u_shift (
    .clk   (clk),
    .rst_n (rst_n),
    .cs_n  (cs_n),
    .sck   (sck),
    .sdi   (sdi),
    .word8 (word8_sel),
    .data  (filt),
    .status(status),
    .sdo   (sdo)
  );

  assign fault_d = over_temp | uv_alarm;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) fault_q <= 1'b0;
    else        fault_q <= fault_d;
  end

  assign fault = fault_q;

  assert_fault_follow_R8: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> fault == ($past(over_temp) || $past(uv_alarm)));
endmodule

// File: tb/tb_din_serializer.sv
module tb_din_serializer;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1, sck = 1'b0, word8 = 1'b0, zero = 1'b0;
  logic [7:0] in_a = '0, in_b = '0;
  logic [1:0] db_a = '0, db_b = '0;
  logic uva_a = 0, uvw_a = 0, ot_a = 0, uva_b = 0, uvw_b = 0, ot_b = 0;
  logic sdo_a, sdo_b, fault_a, fault_b;
  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  din_serializer dut (
    .clk(clk), .rst_n(rst_n), .in_raw(in_a), .db_sel(db_a), .word8_sel(word8),
    .uv_alarm(uva_a), .uv_warn(uvw_a), .over_temp(ot_a), .cs_n(cs_n), .sck(sck),
    .sdi(sdo_b), .sdo(sdo_a), .fault(fault_a));

  din_serializer dut_b (
    .clk(clk), .rst_n(rst_n), .in_raw(in_b), .db_sel(db_b), .word8_sel(word8),
    .uv_alarm(uva_b), .uv_warn(uvw_b), .over_temp(ot_b), .cs_n(cs_n), .sck(sck),
    .sdi(zero), .sdo(sdo_b), .fault(fault_b));

  function automatic logic [4:0] ref_crc(input logic [7:0] d);
    logic [7:0] c = d;
    for (int i = 0; i < 8; i++) c = c[7] ? ((c << 1) ^ 8'hA8) : (c << 1);
    return c[7:3];
  endfunction

  function automatic logic [15:0] ref_word(input logic [7:0] d, input logic uva,
                                           input logic ot, input logic uvw);
    return {d, ref_crc(d), ~uva, ot, ~uvw};
  endfunction

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic run_frame(input int nbits, input bit chg, output logic [31:0] got);
    got = '0;
    @(negedge clk); cs_n = 1'b0;
    @(negedge clk);
    for (int i = 0; i < nbits; i++) begin
      got = {got[30:0], sdo_a};
      if (chg && i == 0) begin
        in_a = ~in_a; in_b = ~in_b; uva_a = ~uva_a; ot_b = ~ot_b; uvw_a = ~uvw_a;
      end
      sck = 1'b1;
      @(negedge clk); sck = 1'b0;
      @(negedge clk);
    end
    cs_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] got, exp;
    logic [7:0]  sa, sb;
    logic        s_uva_a, s_ot_a, s_uvw_a, s_uva_b, s_ot_b, s_uvw_b;
    int seed;
    seed = $urandom(32'h5EED1234);
    repeat (3) @(negedge clk);
    check({30'd0, sdo_a, fault_a}, 32'd0, "R1 in reset");
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check({30'd0, sdo_a, fault_a}, 32'd0, "R1 after reset");

    // directed 16-bit chain
    in_a = 8'hA5; in_b = 8'h3C; uva_a = 1; ot_b = 1; uvw_b = 1;
    repeat (2) @(negedge clk);
    run_frame(32, 0, got);
    check(got[31:16], {16'd0, ref_word(8'hA5, 1, 0, 0)}, "R3 R4 R5 near word");
    check(got[15:0], {16'd0, ref_word(8'h3C, 0, 1, 1)}, "R6 far word follows");
    check({27'd0, ref_crc(8'h80)}, 32'h1C, "R4 bench crc sanity");

    // directed 8-bit chain
    word8 = 1; uva_a = 0; ot_b = 0; uvw_b = 0; in_a = 8'h81; in_b = 8'h7E;
    repeat (2) @(negedge clk);
    run_frame(24, 0, got);
    check(got[23:0], {8'd0, 8'h81, 8'h7E, 8'h00}, "R2 R6 byte mode chain");

    // R7: inputs changed after load
    word8 = 0; in_a = 8'h5A; in_b = 8'hC3; uva_a = 0; ot_b = 0; uvw_a = 0;
    repeat (2) @(negedge clk);
    run_frame(32, 1, got);
    check(got, {ref_word(8'h5A, 0, 0, 0), ref_word(8'hC3, 0, 0, 0)}, "R7 word frozen at load");

    // random frames
    for (int k = 0; k < 40; k++) begin
      word8 = $urandom_range(0, 1);
      in_a = $urandom(); in_b = $urandom();
      {uva_a, ot_a, uvw_a, uva_b, ot_b, uvw_b} = 6'($urandom());
      sa = in_a; sb = in_b;
      {s_uva_a, s_ot_a, s_uvw_a, s_uva_b, s_ot_b, s_uvw_b} = {uva_a, ot_a, uvw_a, uva_b, ot_b, uvw_b};
      repeat (2) @(negedge clk);
      if (word8) begin
        run_frame(16, 0, got);
        check(got, {16'd0, sa, sb}, "R2 R6 random byte mode");
      end else begin
        run_frame(32, 0, got);
        exp = {ref_word(sa, s_uva_a, s_ot_a, s_uvw_a), ref_word(sb, s_uva_b, s_ot_b, s_uvw_b)};
        check(got, exp, "R3 R4 R5 R6 random status mode");
      end
    end

    // R8 fault
    @(negedge clk); ot_a = 0; uva_a = 0;
    @(negedge clk); check({31'd0, fault_a}, 0, "R8 no alarm");
    ot_a = 1; @(negedge clk); check({31'd0, fault_a}, 1, "R8 overtemp");
    ot_a = 0; uva_a = 1; @(negedge clk); check({31'd0, fault_a}, 1, "R8 undervoltage");
    uva_a = 0; uvw_a = 1; @(negedge clk); check({31'd0, fault_a}, 0, "R8 warning only");
    uvw_a = 0;

    // R9 debounce
    word8 = 1; db_a = 2'b00; in_a = 8'h00; in_b = 8'h11;
    repeat (3) @(negedge clk);
    db_a = 2'b01; in_a = 8'hFF;
    repeat (3) @(negedge clk);
    in_a = 8'h00;
    repeat (6) @(negedge clk);
    run_frame(16, 0, got);
    check(got, {16'd0, 8'h00, 8'h11}, "R9 short glitch ignored");
    in_a = 8'hFF;
    repeat (5) @(negedge clk);
    run_frame(16, 0, got);
    check(got, {16'd0, 8'hFF, 8'h11}, "R9 short hold taken");
    db_a = 2'b11; in_a = 8'h0F;
    repeat (63) @(negedge clk);
    in_a = 8'hFF;
    repeat (4) @(negedge clk);
    run_frame(16, 0, got);
    check(got, {16'd0, 8'hFF, 8'h11}, "R9 long glitch ignored");
    in_a = 8'h0F;
    repeat (66) @(negedge clk);
    run_frame(16, 0, got);
    check(got, {16'd0, 8'h0F, 8'h11}, "R9 long hold taken");
    db_a = 2'b10; in_a = 8'hF0;
    repeat (10) @(negedge clk);
    run_frame(16, 0, got);
    check(got, {16'd0, 8'h0F, 8'h11}, "R9 medium not yet");
    repeat (10) @(negedge clk);
    run_frame(16, 0, got);
    check(got, {16'd0, 8'hF0, 8'h11}, "R9 medium taken");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule